// File: doc/BRIEF.md
# Interrupt Pin Request Tracker

This block keeps the request state of every input pin of an interrupt router. Each cycle it samples the raw pin levels and applies each entry's polarity, trigger mode and mask. From these it maintains a pending bit and an accepted-but-unacknowledged (remote-IRR) bit for every pin. Pins that need service go to a downstream dispatcher one at a time, through a valid/done handshake. When the dispatcher finishes, it reports whether the interrupt actually reached a target.

End-of-interrupt notices arrive as an 8-bit vector. The tracker finds the lowest-numbered pin programmed with that vector and clears its remote-IRR bit. If that pin is still pending and unmasked, the tracker delivers it again. A level pin is marked as accepted only when a delivery succeeded. A failed delivery therefore never leaves a line that no later acknowledge can free. Configuration comes from a register block elsewhere, and the per-pin state is exported to that block for read-back.

Top module: `irq_pin_tracker`

## Requirements
- R1: The effective level of a pin is its raw input XOR its polarity bit (1 = active low). While the effective level is 0, the pin's pending bit (`pend_state`) is 0. A level-mode pin with effective level 1 has its pending bit set one cycle later.
- R2: An edge-mode pin (`cfg_level` bit = 0) requests exactly one delivery for each 0-to-1 change of its effective level. Its pending bit is cleared once that delivery completes, even while the input stays high.
- R3: A level-mode pin (`cfg_level` bit = 1) requests delivery while it is pending, unmasked, not already in flight and its remote-IRR bit is 0. While remote-IRR is 1, no further delivery happens.
- R4: A pin's remote-IRR bit (`rirr_state`) is set only when a level-mode delivery completes with `dlv_injected` = 1. A level delivery that completes with `dlv_injected` = 0 leaves remote-IRR at 0 and is retried. Edge-mode pins never set remote-IRR.
- R5: A masked pin (`cfg_mask` bit = 1) is never delivered. A masked edge request is dropped and its pending bit cleared. A masked pending level pin is delivered once it is unmasked.
- R6: Only one delivery is outstanding at a time, and the lowest-numbered requesting pin is served first. `dlv_valid`, `dlv_pin` and `dlv_vector` hold steady until `dlv_done`.
- R7: An EOI clears remote-IRR only on the lowest-numbered pin whose vector equals `eoi_vector`. Pins with the same vector at higher indices are left untouched, and an EOI that matches no pin changes nothing.
- R8: If the pin matched by an EOI is unmasked and still pending, it is delivered again. When that delivery is injected, remote-IRR is set again.
- R9: After reset, no delivery is requested and all pending and remote-IRR bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Raw interrupt input levels |
| cfg_polarity | input | NPINS | 1 = pin is active low |
| cfg_level | input | NPINS | 1 = level trigger, 0 = edge trigger |
| cfg_mask | input | NPINS | 1 = pin masked |
| cfg_vector | input | NPINS*VW | Vector of each pin, pin i at bits [i*VW +: VW] |
| eoi_valid | input | 1 | End-of-interrupt notice valid this cycle |
| eoi_vector | input | VW | Vector being acknowledged |
| dlv_valid | output | 1 | Delivery request to the dispatcher |
| dlv_pin | output | $clog2(NPINS) | Pin being delivered |
| dlv_vector | output | VW | Vector of the pin being delivered |
| dlv_level | output | 1 | Trigger mode of the pin being delivered |
| dlv_done | input | 1 | Dispatcher finished the current delivery |
| dlv_injected | input | 1 | Dispatcher reached a target (valid with dlv_done) |
| pend_state | output | NPINS | Pending bit of each pin |
| rirr_state | output | NPINS | Remote-IRR bit of each pin |

## Verification
A remote-IRR bit left set by a failed delivery shows up as a level line that goes quiet for good. Its vector never appears on `dlv_vector` again, and a later EOI does not revive it. So the bench counts the exact list of deliveries, with their order, and reads `rirr_state` a few cycles after each handshake. A stale pending or request bit shows up within one handshake (about five cycles) as an extra delivery, which the scoreboard rejects as unexpected. A wrong EOI lookup shows up as the wrong bit clearing in `rirr_state` in the cycle after the notice.

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int NPINS = 8,
  parameter int VW    = 8,
  localparam int PW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    pin_in,
  input  logic [NPINS-1:0]    cfg_polarity,
  input  logic [NPINS-1:0]    cfg_level,
  input  logic [NPINS-1:0]    cfg_mask,
  input  logic [NPINS*VW-1:0] cfg_vector,
  input  logic                eoi_valid,
  input  logic [VW-1:0]       eoi_vector,
  output logic                dlv_valid,
  output logic [PW-1:0]       dlv_pin,
  output logic [VW-1:0]       dlv_vector,
  output logic                dlv_level,
  input  logic                dlv_done,
  input  logic                dlv_injected,
  output logic [NPINS-1:0]    pend_state,
  output logic [NPINS-1:0]    rirr_state
);

  logic [NPINS-1:0] eff, eff_q, rise;
  logic [NPINS-1:0] pending, rirr, req;
  logic [NPINS-1:0] pend_n, rirr_n, req_n;
  logic             busy, busy_n;
  logic [PW-1:0]    cur, cur_n;
  logic             eoi_hit, gnt_any;
  logic [PW-1:0]    eoi_idx, gnt_idx;

  assign eff  = pin_in ^ cfg_polarity;
  assign rise = eff & ~eff_q;

  assign dlv_valid  = busy;
  assign dlv_pin    = cur;
  assign dlv_vector = cfg_vector[cur*VW +: VW];
  assign dlv_level  = cfg_level[cur];
  assign pend_state = pending;
  assign rirr_state = rirr;

  always_comb begin
    eoi_hit = 1'b0;
    eoi_idx = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (cfg_vector[i*VW +: VW] == eoi_vector) begin
        eoi_hit = 1'b1;
        eoi_idx = PW'(i);
      end
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (req[i]) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(i);
      end
  end

  always_comb begin
    pend_n = pending;
    rirr_n = rirr;
    req_n  = req;
    busy_n = busy;
    cur_n  = cur;
    if (eoi_valid && eoi_hit) begin
      rirr_n[eoi_idx] = 1'b0;
      if (!cfg_mask[eoi_idx] && pending[eoi_idx])
        req_n[eoi_idx] = 1'b1;
    end
    for (int i = 0; i < NPINS; i++) begin
      if (!eff[i])
        pend_n[i] = 1'b0;
      else if (cfg_level[i]) begin
        pend_n[i] = 1'b1;
        if (!cfg_mask[i] && !rirr[i] && !(busy && cur == PW'(i)))
          req_n[i] = 1'b1;
      end else if (rise[i]) begin
        pend_n[i] = 1'b1;
        req_n[i]  = 1'b1;
      end
    end
    if (busy && dlv_done) begin
      busy_n = 1'b0;
      if (dlv_injected && cfg_level[cur])
        rirr_n[cur] = 1'b1;
      if (!cfg_level[cur] && !rise[cur])
        pend_n[cur] = 1'b0;
    end
    if (!busy && gnt_any) begin
      req_n[gnt_idx] = 1'b0;
      if (cfg_mask[gnt_idx]) begin
        if (!cfg_level[gnt_idx] && !rise[gnt_idx])
          pend_n[gnt_idx] = 1'b0;
      end else begin
        busy_n = 1'b1;
        cur_n  = gnt_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q   <= '0;
      pending <= '0;
      rirr    <= '0;
      req     <= '0;
      busy    <= 1'b0;
      cur     <= '0;
    end else begin
      eff_q   <= eff;
      pending <= pend_n;
      rirr    <= rirr_n;
      req     <= req_n;
      busy    <= busy_n;
      cur     <= cur_n;
    end
  end

  AST_PEND_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(eff)) == '0)); // R1

  AST_RIRR_ONLY_ON_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rirr & ~$past(rirr)) != '0) |-> $past(busy && dlv_done && dlv_injected && cfg_level[cur])); // R4

  AST_NO_MASKED_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> !cfg_mask[dlv_pin]); // R5

  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_done) |=> (dlv_valid && $stable(dlv_pin))); // R6

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_hit && !(busy && dlv_done && cur == eoi_idx)) |=> !rirr[$past(eoi_idx)]); // R7

endmodule

// File: tb/tb_irq_pin_tracker.sv
module tb_irq_pin_tracker;
  localparam int NPINS = 8;
  localparam int VW    = 8;
  localparam int PW    = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPINS-1:0]    pin_in = '0;
  logic [NPINS-1:0]    cfg_polarity = '0;
  logic [NPINS-1:0]    cfg_level = '0;
  logic [NPINS-1:0]    cfg_mask = '1;
  logic [NPINS*VW-1:0] cfg_vector = '0;
  logic                eoi_valid = 1'b0;
  logic [VW-1:0]       eoi_vector = '0;
  logic                dlv_valid;
  logic [PW-1:0]       dlv_pin;
  logic [VW-1:0]       dlv_vector;
  logic                dlv_level;
  logic                dlv_done = 1'b0;
  logic                dlv_injected = 1'b0;
  logic [NPINS-1:0]    pend_state, rirr_state;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [PW+VW:0] exp_q[$];
  string          tag_q[$];

  always #2 clk = ~clk;

  irq_pin_tracker #(.NPINS(NPINS), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_polarity(cfg_polarity),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_vector(cfg_vector),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
    .dlv_done(dlv_done), .dlv_injected(dlv_injected),
    .pend_state(pend_state), .rirr_state(rirr_state));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic expect_dlv(input int pin, input int vec, input bit inj, input string req);
    exp_q.push_back({PW'(pin), VW'(vec), inj});
    tag_q.push_back(req);
  endtask

  task automatic cfg(input int pin, input int vec, input bit pol, input bit lvl, input bit msk);
    cfg_vector[pin*VW +: VW] = VW'(vec);
    cfg_polarity[pin] = pol;
    cfg_level[pin]    = lvl;
    cfg_mask[pin]     = msk;
  endtask

  task automatic eoi(input int vec);
    @(negedge clk);
    eoi_vector = VW'(vec);
    eoi_valid  = 1'b1;
    @(negedge clk);
    eoi_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected deliveries and answers the handshake
  initial begin
    forever begin
      @(negedge clk);
      if (dlv_valid && rst_n) begin
        logic [PW+VW:0] item;
        string tg;
        bit inj;
        inj = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected delivery", {dlv_pin, dlv_vector}, 0);
        end else begin
          item = exp_q.pop_front();
          tg   = tag_q.pop_front();
          inj  = item[0];
          chk({dlv_pin, dlv_vector} == item[PW+VW:1], tg, {dlv_pin, dlv_vector}, item[PW+VW:1]);
        end
        @(negedge clk);
        @(negedge clk);
        chk(dlv_valid == 1'b1, "R6 held until done", dlv_valid, 1);
        dlv_done     = 1'b1;
        dlv_injected = inj;
        @(negedge clk);
        dlv_done     = 1'b0;
        dlv_injected = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R9 reset state
    chk(dlv_valid == 1'b0, "R9 no delivery", dlv_valid, 0);
    chk(pend_state == '0, "R9 pending clear", pend_state, 0);
    chk(rirr_state == '0, "R9 remote-IRR clear", rirr_state, 0);

    // R2 edge pin delivers once, pending cleared while input stays high
    cfg(2, 'h32, 0, 0, 0);
    expect_dlv(2, 'h32, 1, "R2 edge delivery");
    pin_in[2] = 1'b1;
    idle(15);
    chk(pend_state[2] == 1'b0, "R2 pending cleared", pend_state[2], 0);
    chk(rirr_state[2] == 1'b0, "R4 edge leaves remote-IRR", rirr_state[2], 0);
    pin_in[2] = 1'b0;
    idle(2);

    // R3 level pin, injected: remote-IRR set, no repeat while held
    cfg(3, 'h41, 0, 1, 0);
    expect_dlv(3, 'h41, 1, "R3 level delivery");
    pin_in[3] = 1'b1;
    idle(20);
    chk(rirr_state[3] == 1'b1, "R4 remote-IRR set on inject", rirr_state[3], 1);
    chk(exp_q.size() == 0, "R3 single delivery", exp_q.size(), 0);
    // R8 EOI while still pending re-delivers
    expect_dlv(3, 'h41, 1, "R8 re-delivery after EOI");
    eoi('h41);
    idle(12);
    chk(rirr_state[3] == 1'b1, "R8 remote-IRR set again", rirr_state[3], 1);
    pin_in[3] = 1'b0;
    idle(2);
    eoi('h41);
    idle(6);
    chk(rirr_state[3] == 1'b0, "R7 EOI clears remote-IRR", rirr_state[3], 0);

    // R4 failed injection retried; active-low polarity (R1)
    pin_in[4] = 1'b1;
    cfg(4, 'h50, 1, 1, 0);
    idle(4);
    chk(pend_state[4] == 1'b0, "R1 inactive low-polarity pin", pend_state[4], 0);
    expect_dlv(4, 'h50, 0, "R4 first attempt fails");
    expect_dlv(4, 'h50, 1, "R4 retry after failure");
    pin_in[4] = 1'b0;
    idle(20);
    chk(rirr_state[4] == 1'b1, "R4 remote-IRR after success", rirr_state[4], 1);
    chk(pend_state[4] == 1'b1, "R1 pending while active", pend_state[4], 1);
    pin_in[4] = 1'b1;
    idle(2);
    chk(pend_state[4] == 1'b0, "R1 pending drops with level", pend_state[4], 0);
    eoi('h50);
    idle(6);

    // R5 masked edge dropped, masked level delivered on unmask
    cfg(5, 'h60, 0, 0, 1);
    pin_in[5] = 1'b1;
    idle(8);
    chk(pend_state[5] == 1'b0, "R5 masked edge dropped", pend_state[5], 0);
    pin_in[5] = 1'b0;
    cfg(6, 'h61, 0, 1, 1);
    pin_in[6] = 1'b1;
    idle(10);
    chk(pend_state[6] == 1'b1, "R5 masked level stays pending", pend_state[6], 1);
    chk(rirr_state[6] == 1'b0, "R5 masked level not delivered", rirr_state[6], 0);
    expect_dlv(6, 'h61, 1, "R5 delivery on unmask");
    cfg_mask[6] = 1'b0;
    idle(12);
    chk(rirr_state[6] == 1'b1, "R5 remote-IRR after unmask", rirr_state[6], 1);

    // R7 duplicate vectors: lowest index only; unmatched EOI ignored
    cfg(7, 'h61, 0, 1, 0);
    expect_dlv(7, 'h61, 1, "R3 second level pin");
    pin_in[7] = 1'b1;
    idle(12);
    pin_in[6] = 1'b0;
    pin_in[7] = 1'b0;
    idle(2);
    eoi('h99);
    idle(3);
    chk(rirr_state[7:6] == 2'b11, "R7 unmatched EOI ignored", rirr_state[7:6], 3);
    eoi('h61);
    idle(3);
    chk(rirr_state[7:6] == 2'b10, "R7 lowest match only", rirr_state[7:6], 2);
    eoi('h61);
    idle(3);
    chk(rirr_state[7] == 1'b1, "R7 higher duplicate untouched", rirr_state[7], 1);

    // R6 lowest pin first
    cfg(0, 'h10, 0, 0, 0);
    cfg(1, 'h11, 0, 0, 0);
    expect_dlv(0, 'h10, 1, "R6 lowest pin first");
    expect_dlv(1, 'h11, 1, "R6 next pin second");
    pin_in[1:0] = 2'b11;
    idle(3);
    pin_in[1:0] = 2'b00;
    idle(20);
    chk(exp_q.size() == 0, "R6 all expected deliveries seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule